// File: doc/BRIEF.md
# Asynchronous Byte-Lane Static RAM Controller

This block is a clocked front-end for an external asynchronous static RAM of 64K words by 16 bits. The RAM has active-low chip, output and write strobes and one active-low enable per byte lane. A host issues single-word requests, each with a read/write flag, a word address, write data and a byte-lane mask. The controller then produces the strobe sequence the RAM expects and, for reads, hands back the captured word together with a one-cycle completion pulse.

Every access walks through four phases: idle, address setup, strobe and recovery. Address and lane enables are set up before the strobe falls and held after it rises. The setup and recovery lengths are build parameters. The strobe length comes from a wait-state count that is sampled when the request is accepted. The shared data bus is split into an output, an output-enable and an input. The controller never drives it while the RAM's outputs are enabled, and it leaves a released cycle between a write and a following read.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, chip, output and write strobes and every lane enable are high (inactive), the data driver enable is low, `done_o` is low, `ready_o` is high and `rd_data_o` is zero.
- R2: A request is accepted on a rising clock edge only when `req_valid_i` and `ready_o` are high and the lane mask is non-zero. Mask bit 0 selects data bits 7:0 (`mem_lane_n_o[0]` low) and mask bit 1 selects bits 15:8 (`mem_lane_n_o[1]` low). A request made while `ready_o` is low, or with mask 00, is dropped: the chip strobe stays high, no completion pulse follows and memory is left unchanged.
- R3: Each access keeps chip select low, with address and selected lanes valid, for exactly `SETUP_CYC` cycles before the strobe falls. The strobe then stays low for `cfg_wait_i + 1` cycles. Chip select, address and lanes are held for exactly `HOLD_CYC` cycles after the strobe rises.
- R4: A write pulls the write strobe low while the output strobe stays high. The driver enable is high and `mem_dq_o` equals the write data from setup through recovery. Only the masked byte lanes of the addressed word change.
- R5: A read pulls the output strobe low while the write strobe stays high and the driver enable stays low. The word is captured on the last strobe cycle, and byte lanes outside the mask read as zero in `rd_data_o`.
- R6: `done_o` is high for exactly one cycle per access, reads and writes alike, in cycle `SETUP_CYC + cfg_wait + 2` counted from the accepting edge. `rd_data_o` changes only on a read.
- R7: The address does not change while the write strobe is low, nor in the cycle after the write strobe rises.
- R8: The driver enable is never high while the output strobe is low, and it has been low for at least one full cycle before the output strobe falls.
- R9: The output and write strobes are never low together, and neither is low while chip select is high.
- R10: The wait-state count is captured at acceptance: changing `cfg_wait_i` during an access does not change that access's strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_mask_i | input | DATA_W/8 | Byte-lane select, bit n = bits 8n+7:8n |
| cfg_wait_i | input | WAIT_W | Wait states added to the one-cycle strobe |
| ready_o | output | 1 | Controller idle, a request can be accepted |
| rd_data_o | output | DATA_W | Last read word, unselected lanes zero |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_ce_n_o | output | 1 | RAM chip select, active low |
| mem_oe_n_o | output | 1 | RAM output strobe, active low |
| mem_we_n_o | output | 1 | RAM write strobe, active low |
| mem_lane_n_o | output | DATA_W/8 | RAM byte-lane enables, active low |
| mem_dq_o | output | DATA_W | Data driven towards the RAM |
| mem_dq_oe_o | output | 1 | Enable for the data drivers |
| mem_dq_i | input | DATA_W | Data returned from the RAM |

## Verification
The bench builds the block with `SETUP_CYC = 2`, `HOLD_CYC = 2` and a 3-bit wait-state field, keeping the 16-bit address and data. Setup and recovery longer than one cycle show whether the phase counters reload and count down correctly rather than happening to work at length one. The 3-bit wait field lets both strobe extremes (1 and 8 cycles) appear often under random stimulus. The full 16-bit address lets the top word be used as a directed case.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;

   function automatic int unsigned bits_for(input int unsigned value);
      int unsigned w;
      w = $clog2(value + 1);
      return (w < 1) ? 1 : w;
   endfunction

   function automatic int unsigned max_of3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned WAIT_W    = 4,
   parameter int unsigned SETUP_CYC = 1,
   parameter int unsigned HOLD_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              start_wr_i,
   input  logic [WAIT_W-1:0] start_wait_i,
   output logic              ready_o,
   output logic              sel_nx_o,
   output logic              sample_o,
   output logic              ce_n_o,
   output logic              oe_n_o,
   output logic              we_n_o,
   output logic              dq_oe_o,
   output logic              done_o
);

   localparam int unsigned CNT_W = max_of3(WAIT_W, bits_for(SETUP_CYC), bits_for(HOLD_CYC));
   localparam logic [CNT_W-1:0] SETUP_LOAD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LOAD  = CNT_W'(HOLD_CYC - 1);

   phase_e            st_q, st_nx;
   logic [CNT_W-1:0]  cnt_q, cnt_nx;
   logic              wr_q, wr_nx;
   logic [WAIT_W-1:0] wait_q;
   logic              cnt_zero;
   logic              ce_n_q, oe_n_q, we_n_q, dq_oe_q, done_q;

   assign cnt_zero = (cnt_q == '0);

   always_comb begin
      st_nx  = st_q;
      cnt_nx = cnt_q;
      wr_nx  = wr_q;
      unique case (st_q)
         PH_IDLE: begin
            if (start_i) begin
               st_nx  = PH_SETUP;
               cnt_nx = SETUP_LOAD;
               wr_nx  = start_wr_i;
            end
         end
         PH_SETUP: begin
            if (cnt_zero) begin
               st_nx  = PH_STROBE;
               cnt_nx = CNT_W'(wait_q);
            end else begin
               cnt_nx = cnt_q - 1'b1;
            end
         end
         PH_STROBE: begin
            if (cnt_zero) begin
               st_nx  = PH_HOLD;
               cnt_nx = HOLD_LOAD;
            end else begin
               cnt_nx = cnt_q - 1'b1;
            end
         end
         PH_HOLD: begin
            if (cnt_zero) st_nx = PH_IDLE;
            else          cnt_nx = cnt_q - 1'b1;
         end
         default: st_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PH_IDLE;
         cnt_q   <= '0;
         wr_q    <= 1'b0;
         wait_q  <= '0;
         ce_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         we_n_q  <= 1'b1;
         dq_oe_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         st_q    <= st_nx;
         cnt_q   <= cnt_nx;
         wr_q    <= wr_nx;
         if (start_i && (st_q == PH_IDLE)) wait_q <= start_wait_i;
         ce_n_q  <= (st_nx == PH_IDLE);
         we_n_q  <= !((st_nx == PH_STROBE) && wr_nx);
         oe_n_q  <= !((st_nx == PH_STROBE) && !wr_nx);
         dq_oe_q <= (st_nx != PH_IDLE) && wr_nx;
         done_q  <= (st_q == PH_STROBE) && cnt_zero;
      end
   end

   assign ready_o  = (st_q == PH_IDLE);
   assign sel_nx_o = (st_nx != PH_IDLE);
   assign sample_o = (st_q == PH_STROBE) && cnt_zero && !wr_q;
   assign ce_n_o   = ce_n_q;
   assign oe_n_o   = oe_n_q;
   assign we_n_o   = we_n_q;
   assign dq_oe_o  = dq_oe_q;
   assign done_o   = done_q;

   // Phase-length observers: count strobe-low and setup cycles at the pins.
   logic             strb_n;
   logic [CNT_W:0]   strobe_run;
   logic [CNT_W:0]   setup_run;

   assign strb_n = oe_n_q & we_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_run <= '0;
         setup_run  <= '0;
      end else begin
         strobe_run <= strb_n ? '0 : strobe_run + 1'b1;
         if (ce_n_q)      setup_run <= '0;
         else if (strb_n) setup_run <= setup_run + 1'b1;
      end
   end

   assert_strobe_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_n) |-> (strobe_run == ((CNT_W+1)'(wait_q) + (CNT_W+1)'(1))));

   assert_setup_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb_n) |-> (setup_run == (CNT_W+1)'(SETUP_CYC)));

   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n_q && !we_n_q));

   assert_strobe_needs_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n_q || !we_n_q) |-> !ce_n_q);

   assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe_q |-> oe_n_q);

   assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_n_q) |-> !$past(dq_oe_q));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   assert_select_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce_n_q) |-> $past(start_i));

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sel_nx_i,
   input  logic              sample_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   input  logic [LANES-1:0]  req_mask_i,
   input  logic [DATA_W-1:0] dq_in_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LANES-1:0]  lane_n_o,
   output logic [DATA_W-1:0] dq_out_o,
   output logic [DATA_W-1:0] rd_data_o
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] dout_q;
   logic [LANES-1:0]  mask_q, mask_nx, lane_n_q;
   logic [DATA_W-1:0] rd_q;

   assign mask_nx = start_i ? req_mask_i : mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         dout_q   <= '0;
         mask_q   <= '0;
         lane_n_q <= '1;
      end else begin
         if (start_i) begin
            addr_q <= req_addr_i;
            dout_q <= req_wdata_i;
            mask_q <= req_mask_i;
         end
         lane_n_q <= sel_nx_i ? ~mask_nx : '1;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q[g*8 +: 8] <= '0;
         end else if (sample_i) begin
            rd_q[g*8 +: 8] <= mask_q[g] ? dq_in_i[g*8 +: 8] : 8'h00;
         end
      end
   end

   assign addr_o    = addr_q;
   assign lane_n_o  = lane_n_q;
   assign dq_out_o  = dout_q;
   assign rd_data_o = rd_q;

   assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((lane_n_q != '1) && $past(lane_n_q != '1)) |-> $stable(addr_q));

   assert_lanes_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((lane_n_q != '1) && $past(lane_n_q != '1)) |-> $stable(lane_n_q));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned WAIT_W    = 4,
   parameter int unsigned SETUP_CYC = 1,
   parameter int unsigned HOLD_CYC  = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid_i,
   input  logic                  req_write_i,
   input  logic [ADDR_W-1:0]     req_addr_i,
   input  logic [DATA_W-1:0]     req_wdata_i,
   input  logic [DATA_W/8-1:0]   req_mask_i,
   input  logic [WAIT_W-1:0]     cfg_wait_i,
   output logic                  ready_o,
   output logic [DATA_W-1:0]     rd_data_o,
   output logic                  done_o,
   output logic [ADDR_W-1:0]     mem_addr_o,
   output logic                  mem_ce_n_o,
   output logic                  mem_oe_n_o,
   output logic                  mem_we_n_o,
   output logic [DATA_W/8-1:0]   mem_lane_n_o,
   output logic [DATA_W-1:0]     mem_dq_o,
   output logic                  mem_dq_oe_o,
   input  logic [DATA_W-1:0]     mem_dq_i
);

   localparam int unsigned LANES = DATA_W / 8;

   if ((DATA_W % 8) != 0 || DATA_W == 0) begin : g_bad_width
      $error("sram_async_ctrl: DATA_W must be a non-zero multiple of 8");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("sram_async_ctrl: SETUP_CYC must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("sram_async_ctrl: HOLD_CYC must be at least 1");
   end
   if (WAIT_W < 1 || ADDR_W < 1) begin : g_bad_field
      $error("sram_async_ctrl: WAIT_W and ADDR_W must be at least 1");
   end

   logic ready, start, sel_nx, sample;

   assign start = req_valid_i && ready && (|req_mask_i);

   sram_phase_seq #(
      .WAIT_W    (WAIT_W),
      .SETUP_CYC (SETUP_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .start_wr_i   (req_write_i),
      .start_wait_i (cfg_wait_i),
      .ready_o      (ready),
      .sel_nx_o     (sel_nx),
      .sample_o     (sample),
      .ce_n_o       (mem_ce_n_o),
      .oe_n_o       (mem_oe_n_o),
      .we_n_o       (mem_we_n_o),
      .dq_oe_o      (mem_dq_oe_o),
      .done_o       (done_o)
   );

   sram_lane_path #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .sel_nx_i    (sel_nx),
      .sample_i    (sample),
      .req_addr_i  (req_addr_i),
      .req_wdata_i (req_wdata_i),
      .req_mask_i  (req_mask_i),
      .dq_in_i     (mem_dq_i),
      .addr_o      (mem_addr_o),
      .lane_n_o    (mem_lane_n_o),
      .dq_out_o    (mem_dq_o),
      .rd_data_o   (rd_data_o)
   );

   assign ready_o = ready;

   assert_addr_still_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n_o |-> $stable(mem_addr_o));

   assert_addr_hold_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n_o) |=> $stable(mem_addr_o));

   assert_lanes_need_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lane_n_o != '1) |-> !mem_ce_n_o);

   assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n_o |-> mem_dq_oe_o);

   assert_rdata_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data_o) |-> $past(!mem_oe_n_o));

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int WW = 3;
   localparam int SETUP = 2;
   localparam int HOLD  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_mask = '0;
   logic [WW-1:0] cfg_wait = '0;
   logic ready, done, ce_n, oe_n, we_n, dq_oe;
   logic [DW-1:0] rd_data, dq_out, dq_in;
   logic [AW-1:0] maddr;
   logic [1:0]    lane_n;

   always #5 clk = ~clk;

   sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW),
                     .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_mask_i(req_mask),
      .cfg_wait_i(cfg_wait), .ready_o(ready), .rd_data_o(rd_data), .done_o(done),
      .mem_addr_o(maddr), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
      .mem_lane_n_o(lane_n), .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in));

   int checks = 0;
   int fails  = 0;

   function automatic logic [15:0] fill_word(input logic [15:0] a);
      return (a * 16'h9E37) ^ 16'h3C3C;
   endfunction

   // RAM model, word store and host-side reference store
   logic [15:0] ram [int];
   logic [15:0] ref_mem [int];

   function automatic logic [15:0] ram_word(input logic [15:0] a);
      return ram.exists(int'(a)) ? ram[int'(a)] : fill_word(a);
   endfunction

   function automatic logic [15:0] ref_word(input logic [15:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : fill_word(a);
   endfunction

   function automatic logic [15:0] masked(input logic [15:0] w, input logic [1:0] m);
      return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
   endfunction

   always @(posedge we_n) begin
      if (ce_n === 1'b0 && dq_oe === 1'b1) begin
         logic [15:0] w;
         w = ram_word(maddr);
         if (!lane_n[0]) w[7:0]  = dq_out[7:0];
         if (!lane_n[1]) w[15:8] = dq_out[15:8];
         ram[int'(maddr)] = w;
      end
   end

   always @(*) begin
      if (ce_n === 1'b0 && oe_n === 1'b0 && we_n === 1'b1) begin
         logic [15:0] w;
         w = ram_word(maddr);
         dq_in = {lane_n[1] ? 8'hA5 : w[15:8], lane_n[0] ? 8'hA5 : w[7:0]};
      end else begin
         dq_in = 16'h5A5A;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Pin-level monitor for R7, R8, R9 and accept counting
   int n_contention = 0, n_gap = 0, n_both = 0, n_noce = 0, n_addr = 0, n_accepts = 0;
   logic p_oe_n = 1'b1, p_dq_oe = 1'b0, p_we_n = 1'b1, pp_we_n = 1'b1, p_ce_n = 1'b1;
   logic [AW-1:0] p_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (dq_oe && !oe_n) n_contention++;
         if (!oe_n && p_oe_n && p_dq_oe) n_gap++;
         if (!oe_n && !we_n) n_both++;
         if ((!oe_n || !we_n) && ce_n) n_noce++;
         if ((!we_n || (p_we_n && !pp_we_n)) && maddr != p_addr) n_addr++;
         if (p_ce_n && !ce_n) n_accepts++;
      end
      pp_we_n = p_we_n; p_we_n = we_n; p_oe_n = oe_n; p_dq_oe = dq_oe;
      p_ce_n = ce_n; p_addr = maddr;
   end

   int expected_accepts = 0;
   logic [15:0] last_rd = '0;

   task automatic do_access(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                            input logic [1:0] m, input logic [WW-1:0] wt, input bit stray);
      int n = 0, n_setup = 0, n_strobe = 0, n_hold = 0, n_done = 0, done_at = 0;
      int bad_drive = 0;
      bit seen_strobe = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_mask = m;
      cfg_wait = wt;
      @(negedge clk);
      req_valid = 1'b0;
      expected_accepts++;
      do begin
         n++;
         if (done) begin n_done++; done_at = n; end
         if (!ce_n) begin
            if (!oe_n || !we_n) begin
               n_strobe++; seen_strobe = 1;
               if (wr && (!we_n == 1'b0 || oe_n == 1'b0)) bad_drive++;
               if (!wr && (!oe_n == 1'b0 || we_n == 1'b0 || dq_oe)) bad_drive++;
            end else if (seen_strobe) n_hold++;
            else n_setup++;
            if (lane_n != ~m || maddr != a) bad_drive++;
            if (wr && (!dq_oe || dq_out != wd)) bad_drive++;
         end
         if (n == 2 && stray) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 16'h0100;
            req_wdata = ~wd; req_mask = 2'b11; cfg_wait = ~wt;
         end
         if (n == 3) req_valid = 1'b0;
         @(negedge clk);
      end while (!ready && n < 64);
      if (done) n_done++;
      check(n_setup == SETUP, "R3", "setup cycles", n_setup, SETUP);
      check(n_strobe == int'(wt) + 1, "R10", "strobe cycles", n_strobe, int'(wt) + 1);
      check(n_hold == HOLD, "R3", "hold cycles", n_hold, HOLD);
      check(n_done == 1, "R6", "done pulse count", n_done, 1);
      check(done_at == SETUP + int'(wt) + 2, "R6", "done cycle", done_at, SETUP + int'(wt) + 2);
      check(bad_drive == 0, wr ? "R4" : "R5", "pin drive during access", bad_drive, 0);
      if (wr) begin
         logic [15:0] w;
         w = ref_word(a);
         if (m[0]) w[7:0]  = wd[7:0];
         if (m[1]) w[15:8] = wd[15:8];
         ref_mem[int'(a)] = w;
         check(rd_data == last_rd, "R6", "read data held over write", rd_data, last_rd);
         check(ram_word(a) == w, "R4", "memory word after write", ram_word(a), w);
      end else begin
         last_rd = masked(ref_word(a), m);
         check(rd_data == last_rd, "R5", "read data", rd_data, last_rd);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_2C41));
      repeat (3) @(negedge clk);
      check(ce_n && oe_n && we_n && lane_n == 2'b11, "R1", "strobes after reset",
            {ce_n, oe_n, we_n, lane_n}, 5'h1F);
      check(!dq_oe && !done && ready && rd_data == 0, "R1", "idle outputs in reset",
            {dq_oe, done, ready}, 3'b001);
      rst_n = 1'b1;
      @(negedge clk);
      check(ce_n && ready && !dq_oe && rd_data == 0, "R1", "idle after reset",
            {ce_n, ready, dq_oe}, 3'b110);

      // Directed corner cases
      do_access(1'b1, 16'hFFFF, 16'hBEEF, 2'b11, 3'd0, 1'b0);
      do_access(1'b0, 16'hFFFF, 16'h0, 2'b01, 3'd7, 1'b0);
      do_access(1'b0, 16'hFFFF, 16'h0, 2'b10, 3'd0, 1'b0);
      do_access(1'b1, 16'h0000, 16'h1234, 2'b01, 3'd3, 1'b1);
      do_access(1'b0, 16'h0000, 16'h0, 2'b11, 3'd2, 1'b0);
      do_access(1'b1, 16'h0000, 16'hAB00, 2'b10, 3'd7, 1'b1);
      do_access(1'b0, 16'h0000, 16'h0, 2'b11, 3'd0, 1'b1);

      // R2: empty lane mask is dropped
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0000; req_wdata = 16'hFFFF;
      req_mask = 2'b00;
      begin
         int bad = 0;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!ce_n || done || !ready) bad++;
         end
         req_valid = 1'b0;
         check(bad == 0, "R2", "mask 00 request ignored", bad, 0);
      end
      do_access(1'b0, 16'h0000, 16'h0, 2'b11, 3'd1, 1'b0);
      check(rd_data == 16'hAB34, "R2", "word after ignored request", rd_data, 16'hAB34);

      // Random traffic
      for (int t = 0; t < 160; t++) begin
         logic wr; logic [15:0] a; logic [1:0] m; logic [WW-1:0] wt;
         wr = 1'($urandom % 2);
         a  = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom % 24);
         m  = 2'(1 + $urandom % 3);
         wt = WW'($urandom % 8);
         do_access(wr, a, 16'($urandom), m, wt, ($urandom % 4) == 0);
      end

      repeat (4) @(negedge clk);
      check(n_accepts == expected_accepts, "R2", "accepted access count", n_accepts, expected_accepts);
      check(n_contention == 0, "R8", "driver on with output strobe low", n_contention, 0);
      check(n_gap == 0, "R8", "no released cycle before read strobe", n_gap, 0);
      check(n_both == 0, "R9", "both strobes low", n_both, 0);
      check(n_noce == 0, "R9", "strobe without chip select", n_noce, 0);
      check(n_addr == 0, "R7", "address moved around write strobe", n_addr, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule